// File: doc/BRIEF.md
# Locality Access Arbiter

This block arbitrates ownership of a memory-mapped security peripheral among several software localities (five by default, numbered 0 to 4). Each locality sees its own 4 KB register window, and the window index is taken from the address bits directly above the window offset. At offset zero of every window sits an 8-bit access register. Software asks for ownership by writing a request bit there. It polls the same register to learn whether it has become the owner, and gives ownership back by writing the active bit while it owns the interface.

Requests that cannot be served at once stay outstanding. Every other locality's window shows a pending flag while any such request waits, so the owner can see that it should hand over. When the interface is free, the highest-numbered waiting locality is granted one clock later. Each grant produces a one-cycle locality-change pulse that an interrupt block can take. After reset the block stays silent until an internal initialisation counter expires: the valid flag reads 0 and writes have no effect until that point.

Top module: `loc_arbiter`

## Requirements
- R1: Access register bit 7 (valid) reads 0 from reset for INIT_CYCLES clocks and reads 1 from then on.
- R2: While the valid flag reads 0, every write is ignored: no request is recorded and no ownership is granted.
- R3: The window is selected by address bits [15:12]. Only offset zero (bits [11:0] all zero) of a window whose index is below NUM_LOC is decoded. Reads elsewhere return 0x00 and writes elsewhere change nothing.
- R4: Writing 1 to bit 1 of a locality's access register records a request. If no locality owns the interface, the grant takes effect on the clock edge after the one on which the write is captured.
- R5: Bit 5 (active) reads 1 only in the window of the current owner. It reads 0 in every window when there is no owner.
- R6: Bit 2 (pending) reads 1 in a window when at least one locality other than that window's locality has an outstanding request.
- R7: When the interface is free and several requests are outstanding, the highest-numbered requesting locality is granted. The others stay pending.
- R8: The owner frees the interface by writing 1 to bit 5 of its own access register. A waiting request is then granted one clock later.
- R9: A request write from the current owner is ignored and leaves no outstanding request. A bit-5 write from a non-owner does not change ownership, but a request bit carried in the same write is still recorded.
- R10: locChange is high for exactly one clock after each grant, in the first cycle in which the new owner's active bit reads 1.
- R11: The bits of the access register other than 7, 5 and 2 always read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| busAddr | input | 16 | Register address; [15:12] selects the locality window |
| busWr | input | 1 | Write strobe for the current cycle |
| busWrData | input | 8 | Write data (bit 1 request, bit 5 release) |
| busRdData | output | 8 | Combinational read data for busAddr |
| locChange | output | 1 | One-cycle pulse when a new owner is granted |

## Verification
Ownership is exercised with a single lone request, with three requests queued behind a busy owner, and with a release that lets the queue drain. These patterns separate the one-clock grant latency from the highest-number-first order, and they show that the pending flag reflects other localities only. Ignored stimulus is tried in four forms: writes before the valid flag rises, a repeat request from the owner, a release from a non-owner, and accesses at a non-zero offset or to a window beyond the last locality. After each, the access registers are read to show that neither the owner nor the pending state moved. A combined request-and-release write from an idle locality confirms that the request half is still taken.

// File: rtl/loc_arb_pkg.sv
package loc_arb_pkg;
  // width of the locality index field taken from the address
  localparam int LOC_W = 4;

  // bit positions inside the access register
  localparam int ACC_VALID  = 7;
  localparam int ACC_ACTIVE = 5;
  localparam int ACC_PEND   = 2;
  localparam int ACC_REQ    = 1;

  // strobes from control to datapath
  typedef struct packed {
    logic             setReq;
    logic             dropOwner;
    logic             grant;
    logic [LOC_W-1:0] wrLoc;
    logic [LOC_W-1:0] grantLoc;
  } arb_strobe_t;
endpackage

// File: rtl/loc_arb_ctrl.sv
module loc_arb_ctrl
  import loc_arb_pkg::*;
#(
  parameter int NUM_LOC     = 5,
  parameter int WIN_LSB     = 12,
  parameter int INIT_CYCLES = 16
) (
  input  logic                     clk,
  input  logic                     rstN,
  input  logic [WIN_LSB+LOC_W-1:0] busAddr,
  input  logic                     busWr,
  input  logic [7:0]               busWrData,
  input  logic                     ownerActive,
  input  logic [LOC_W-1:0]         ownerLoc,
  input  logic [NUM_LOC-1:0]       pendVec,
  output logic                     initDone,
  output arb_strobe_t              strobe
);
  localparam int CNT_W = $clog2(INIT_CYCLES + 1);
  localparam logic [CNT_W-1:0] CNT_END = CNT_W'(INIT_CYCLES);

  logic [CNT_W-1:0] initCnt;
  logic [LOC_W-1:0] winLoc;
  logic             wrHit;
  logic             fromOwner;
  logic [LOC_W-1:0] topLoc;

  // startup initialisation counter
  always_ff @(posedge clk) begin
    if (!rstN)                 initCnt <= '0;
    else if (initCnt != CNT_END) initCnt <= initCnt + 1'b1;
  end
  assign initDone = (initCnt == CNT_END);

  // write decode
  assign winLoc    = busAddr[WIN_LSB+LOC_W-1:WIN_LSB];
  assign wrHit     = initDone && busWr && (busAddr[WIN_LSB-1:0] == '0)
                     && (int'(winLoc) < NUM_LOC);
  assign fromOwner = ownerActive && (ownerLoc == winLoc);

  // highest-numbered pending locality
  always_comb begin
    topLoc = '0;
    for (int i = 0; i < NUM_LOC; i++)
      if (pendVec[i]) topLoc = LOC_W'(i);
  end

  always_comb begin
    strobe.setReq    = wrHit && busWrData[ACC_REQ] && !fromOwner;
    strobe.dropOwner = wrHit && busWrData[ACC_ACTIVE] && fromOwner;
    strobe.grant     = !ownerActive && (pendVec != '0);
    strobe.wrLoc     = winLoc;
    strobe.grantLoc  = topLoc;
  end
endmodule

// File: rtl/loc_arb_dp.sv
module loc_arb_dp
  import loc_arb_pkg::*;
#(
  parameter int NUM_LOC = 5,
  parameter int WIN_LSB = 12
) (
  input  logic                     clk,
  input  logic                     rstN,
  input  arb_strobe_t              strobe,
  input  logic                     initDone,
  input  logic [WIN_LSB+LOC_W-1:0] busAddr,
  output logic                     ownerActive,
  output logic [LOC_W-1:0]         ownerLoc,
  output logic [NUM_LOC-1:0]       pendVec,
  output logic                     locChange,
  output logic [7:0]               busRdData
);
  logic [LOC_W-1:0] rdLoc;
  logic             rdHit;
  logic             otherPend;

  // outstanding requests, one flop per locality
  for (genvar g = 0; g < NUM_LOC; g++) begin : g_pend
    always_ff @(posedge clk) begin
      if (!rstN)
        pendVec[g] <= 1'b0;
      else if (strobe.grant && strobe.grantLoc == LOC_W'(g))
        pendVec[g] <= 1'b0;
      else if (strobe.setReq && strobe.wrLoc == LOC_W'(g))
        pendVec[g] <= 1'b1;
    end
  end

  // ownership state and change event
  always_ff @(posedge clk) begin
    if (!rstN) begin
      ownerActive <= 1'b0;
      ownerLoc    <= '0;
      locChange   <= 1'b0;
    end else begin
      locChange <= strobe.grant;
      if (strobe.grant) begin
        ownerActive <= 1'b1;
        ownerLoc    <= strobe.grantLoc;
      end else if (strobe.dropOwner) begin
        ownerActive <= 1'b0;
      end
    end
  end

  // read path
  assign rdLoc = busAddr[WIN_LSB+LOC_W-1:WIN_LSB];
  assign rdHit = (busAddr[WIN_LSB-1:0] == '0) && (int'(rdLoc) < NUM_LOC);

  always_comb begin
    otherPend = 1'b0;
    for (int i = 0; i < NUM_LOC; i++)
      if (pendVec[i] && rdLoc != LOC_W'(i)) otherPend = 1'b1;
  end

  always_comb begin
    busRdData = '0;
    if (rdHit) begin
      busRdData[ACC_VALID]  = initDone;
      busRdData[ACC_ACTIVE] = ownerActive && (ownerLoc == rdLoc);
      busRdData[ACC_PEND]   = otherPend;
    end
  end
endmodule

// File: rtl/loc_arbiter.sv
module loc_arbiter
  import loc_arb_pkg::*;
#(
  parameter int NUM_LOC     = 5,
  parameter int WIN_LSB     = 12,
  parameter int INIT_CYCLES = 16
) (
  input  logic                     clk,
  input  logic                     rstN,
  input  logic [WIN_LSB+LOC_W-1:0] busAddr,
  input  logic                     busWr,
  input  logic [7:0]               busWrData,
  output logic [7:0]               busRdData,
  output logic                     locChange
);
  arb_strobe_t        strobe;
  logic               initDone;
  logic               ownerActive;
  logic [LOC_W-1:0]   ownerLoc;
  logic [NUM_LOC-1:0] pendVec;

  loc_arb_ctrl #(.NUM_LOC(NUM_LOC), .WIN_LSB(WIN_LSB), .INIT_CYCLES(INIT_CYCLES)) u_ctrl (
    .clk(clk), .rstN(rstN), .busAddr(busAddr), .busWr(busWr), .busWrData(busWrData),
    .ownerActive(ownerActive), .ownerLoc(ownerLoc), .pendVec(pendVec),
    .initDone(initDone), .strobe(strobe)
  );

  loc_arb_dp #(.NUM_LOC(NUM_LOC), .WIN_LSB(WIN_LSB)) u_dp (
    .clk(clk), .rstN(rstN), .strobe(strobe), .initDone(initDone), .busAddr(busAddr),
    .ownerActive(ownerActive), .ownerLoc(ownerLoc), .pendVec(pendVec),
    .locChange(locChange), .busRdData(busRdData)
  );
endmodule

module loc_arb_chk
  import loc_arb_pkg::*;
#(
  parameter int NUM_LOC = 5,
  parameter int WIN_LSB = 12
) (
  input logic                     clk,
  input logic                     rstN,
  input logic [WIN_LSB+LOC_W-1:0] busAddr,
  input logic                     busWr,
  input logic [7:0]               busWrData,
  input logic                     locChange,
  input logic                     initDone,
  input logic                     ownerActive,
  input logic [LOC_W-1:0]         ownerLoc,
  input logic [NUM_LOC-1:0]       pendVec
);
  logic [LOC_W-1:0] winLoc;
  logic             ownerRelWr;
  assign winLoc     = busAddr[WIN_LSB+LOC_W-1:WIN_LSB];
  assign ownerRelWr = busWr && (busAddr[WIN_LSB-1:0] == '0) && busWrData[ACC_ACTIVE]
                      && ownerActive && (winLoc == ownerLoc);

  // R1
  valid_sticky_chk: assert property (@(posedge clk) disable iff (!rstN)
    $past(initDone) |-> initDone);

  // R2
  quiet_before_init_chk: assert property (@(posedge clk) disable iff (!rstN)
    !initDone |-> (pendVec == '0) && !ownerActive);

  // R4
  grant_when_free_chk: assert property (@(posedge clk) disable iff (!rstN)
    (!ownerActive && pendVec != '0) |=> ownerActive && locChange);

  // R5
  owner_in_range_chk: assert property (@(posedge clk) disable iff (!rstN)
    ownerActive |-> int'(ownerLoc) < NUM_LOC);

  // R8
  release_frees_chk: assert property (@(posedge clk) disable iff (!rstN)
    ownerRelWr |=> !ownerActive);

  // R9
  owner_holds_chk: assert property (@(posedge clk) disable iff (!rstN)
    (ownerActive && !ownerRelWr) |=> ownerActive && ownerLoc == $past(ownerLoc) && !locChange);

  // R10
  change_on_grant_chk: assert property (@(posedge clk) disable iff (!rstN)
    locChange |-> ownerActive && !$past(ownerActive));
endmodule

bind loc_arbiter loc_arb_chk #(.NUM_LOC(NUM_LOC), .WIN_LSB(WIN_LSB)) u_chk (
  .clk(clk), .rstN(rstN), .busAddr(busAddr), .busWr(busWr), .busWrData(busWrData),
  .locChange(locChange), .initDone(initDone), .ownerActive(ownerActive),
  .ownerLoc(ownerLoc), .pendVec(pendVec)
);

// File: tb/test_loc_arbiter.sv
module test_loc_arbiter;
  localparam int INIT = 16;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic [15:0] busAddr = '0;
  logic        busWr = 1'b0;
  logic [7:0]  busWrData = '0;
  logic [7:0]  busRdData;
  logic        locChange;
  logic        rdReq = 1'b0;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  typedef struct {
    logic [7:0] rd;
    logic       evt;
    string      tag;
  } item_t;
  item_t q[$];

  always #2.5 clk = ~clk;  // 200 MHz

  loc_arbiter #(.INIT_CYCLES(INIT)) i_loc_arbiter (
    .clk(clk), .rstN(rstN), .busAddr(busAddr), .busWr(busWr),
    .busWrData(busWrData), .busRdData(busRdData), .locChange(locChange)
  );

  // monitor: compares each read against the next expected item
  always @(negedge clk) begin
    if (rdReq && q.size() > 0) begin
      item_t it;
      it = q.pop_front();
      checks++;
      if (busRdData !== it.rd || locChange !== it.evt) begin
        fails++;
        $display("FAIL %s: rd=%02h evt=%0b expected rd=%02h evt=%0b",
                 it.tag, busRdData, locChange, it.rd, it.evt);
      end
    end
  end

  task automatic doWrite(input logic [15:0] a, input logic [7:0] d);
    @(posedge clk); #1;
    rdReq = 1'b0; busAddr = a; busWrData = d; busWr = 1'b1;
  endtask

  task automatic doRead(input logic [15:0] a, input logic [7:0] exp,
                        input logic evt, input string tag);
    item_t it;
    @(posedge clk); #1;
    busWr = 1'b0; busAddr = a;
    it.rd = exp; it.evt = evt; it.tag = tag;
    q.push_back(it);
    rdReq = 1'b1;
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) begin
      @(posedge clk); #1;
      busWr = 1'b0; rdReq = 1'b0;
    end
  endtask

  initial begin
    repeat (3) @(posedge clk);
    #1 rstN = 1'b1;
    // reset state: valid low
    doRead(16'h0000, 8'h00, 1'b0, "R1 valid low after reset");
    // request before init: ignored
    doWrite(16'h3000, 8'h02);
    idle(INIT + 4);
    doRead(16'h3000, 8'h80, 1'b0, "R1/R2 valid high, early request dropped");
    doRead(16'h3000, 8'h80, 1'b0, "R2 no late grant from early request");
    // lone request, one clock grant latency
    doWrite(16'h0000, 8'h02);
    doRead(16'h0000, 8'h80, 1'b0, "R4 not yet granted");
    doRead(16'h0000, 8'hA0, 1'b1, "R4/R10 granted with change pulse");
    doRead(16'h0000, 8'hA0, 1'b0, "R10 pulse lasts one clock");
    // queue behind busy owner
    doWrite(16'h2000, 8'h02);
    doWrite(16'h4000, 8'h02);
    doWrite(16'h1000, 8'h02);
    doRead(16'h0000, 8'hA4, 1'b0, "R6 owner sees pending");
    doRead(16'h2000, 8'h84, 1'b0, "R5/R6 waiter sees others pending");
    // ignored writes
    doWrite(16'h0000, 8'h02);
    doRead(16'h0000, 8'hA4, 1'b0, "R9 owner request ignored");
    doWrite(16'h3000, 8'h20);
    doRead(16'h0000, 8'hA4, 1'b0, "R9 non-owner release ignored");
    doRead(16'h3000, 8'h84, 1'b0, "R9 non-owner window");
    // release: highest waiter wins
    doWrite(16'h0000, 8'h20);
    doRead(16'h4000, 8'h84, 1'b0, "R8 freed, grant next clock");
    doRead(16'h4000, 8'hA4, 1'b1, "R7 highest locality granted");
    doRead(16'h0000, 8'h84, 1'b0, "R5 old owner not active");
    doWrite(16'h4000, 8'h20);
    doRead(16'h2000, 8'h84, 1'b0, "R8 second release");
    doRead(16'h2000, 8'hA4, 1'b1, "R7 next highest granted");
    doWrite(16'h2000, 8'h20);
    doRead(16'h1000, 8'h80, 1'b0, "R8 third release");
    doRead(16'h1000, 8'hA0, 1'b1, "R7 last waiter, no stale owner request");
    // decode limits
    doRead(16'h1004, 8'h00, 1'b0, "R3 non-zero offset reads zero");
    doRead(16'h5000, 8'h00, 1'b0, "R3 window beyond last locality");
    doWrite(16'h5000, 8'h02);
    doWrite(16'h3008, 8'h02);
    doRead(16'h1000, 8'hA0, 1'b0, "R3 out-of-range writes record nothing");
    doWrite(16'h1000, 8'h20);
    doRead(16'h1000, 8'h80, 1'b0, "R8 released to idle");
    doRead(16'h1000, 8'h80, 1'b0, "R3 no phantom grant");
    // combined request+release from idle locality
    doWrite(16'h3000, 8'h22);
    doRead(16'h3000, 8'h80, 1'b0, "R9 combined write, request kept");
    doRead(16'h3000, 8'hA0, 1'b1, "R9 combined write granted");
    // reserved bits
    doWrite(16'h3000, 8'hDD);
    doRead(16'h3000, 8'hA0, 1'b0, "R11 reserved bits read zero");
    idle(2);
    if (q.size() != 0) begin
      checks++; fails++;
      $display("FAIL scoreboard: %0d items left, expected 0", q.size());
    end
    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    repeat (5000) @(posedge clk);
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog: run did not finish, expected completion");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end
endmodule